// File: doc/BRIEF.md
# Tagged Receive FIFO with Status Word

This block sits between a frame deframer and a host. The deframer pushes received bytes, and each byte carries two tags: one marks the final byte of a frame, the other marks a failed frame check. Each byte is stored together with a third tag for overrun in one 11-bit slot. The host pops bytes from the head. While it does so, a read-only 32-bit status word shows the tags of the head entry. This lets the host handle a frame boundary or an error exactly when it reaches the byte concerned.

The status word also carries four live flags:
- head-not-empty for this queue;
- not-full for a companion transmit queue, derived from an occupancy count passed in;
- transmitter-active, mirrored from the transmit engine;
- receiver-in-sync, mirrored from the receive engine.

Occupancy is tracked by a three-state machine:
- `Q_EMPTY`: no stored entries.
- `Q_PARTIAL`: between one and DEPTH-1 stored entries.
- `Q_FULL`: DEPTH stored entries.

Its transitions are:
- FILL_FIRST (`Q_EMPTY` to `Q_PARTIAL`): a push into the empty queue.
- TOP_OFF (`Q_PARTIAL` to `Q_FULL`): a lone push at DEPTH-1 entries.
- DRAIN_LAST (`Q_PARTIAL` to `Q_EMPTY`): a lone pop at one entry.
- FREE_SLOT (`Q_FULL` to `Q_PARTIAL`): a lone pop while full.

Every other combination holds the current state. DEPTH must be at least 2.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. `rd_data` always presents the head byte, and `rd_en` with a non-empty queue removes it at the clock edge.
- R2: When an entry becomes the head, its tags appear on the cycle after that edge: end-of-frame in status bit 4, frame-check error in bit 5, overrun in bit 6. An entry can become the head by a push into an empty queue, by a pop that exposes the next entry, or by a push and pop on a single-entry queue.
- R3: A push while full with no pop in the same cycle is discarded. Occupancy and stored bytes are unchanged.
- R4: A discarded push sets the overrun tag of the most recently stored entry. Earlier entries keep overrun at 0.
- R5: Status layout:

  | Bit | Meaning |
  |---|---|
  | 0 | receiver in sync |
  | 1 | transmitter active |
  | 2 | queue not empty |
  | 3 | transmit queue not full |
  | 4 | end of frame |
  | 5 | frame-check error |
  | 6 | overrun |
  | 31:7 | always 0 |

- R6: After reset, with `tx_level`=0 and both engine flags low, status reads 0x00000008.
- R7: Bit 3 is 1 while `tx_level` < TX_DEPTH and 0 when `tx_level` equals TX_DEPTH.
- R8: Bits 0 and 1 follow `rx_locked` and `tx_busy` in the same cycle.
- R9: When the queue empties, bits 6:4 keep the last head's tags until a new entry becomes the head.
- R10: A push and a pop in the same cycle on a full queue are both accepted, with no loss.
- R11: A pop on an empty queue has no effect on status or on later data.
- R12: Bit 2 rises the cycle after the first accepted push, and falls the cycle after the last entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | push request from deframer |
| wr_data | input | 8 | byte to store |
| wr_last | input | 1 | byte ends its frame (also for aborted frames) |
| wr_crc_bad | input | 1 | frame check failed |
| rd_en | input | 1 | host pop request |
| rd_data | output | 8 | head byte |
| tx_level | input | TXC_W | occupancy of companion transmit queue |
| tx_busy | input | 1 | transmitter sending a frame |
| rx_locked | input | 1 | receiver synchronized |
| status | output | 32 | status word |

## Verification
The bench targets these corner cases, each paired with the failure it exposes:
- **Overrun on a full queue.** A design that stored the extra byte would overwrite live data. A design that marked the wrong slot would show overrun on an earlier byte, or on none.
- **Push and pop together while full.** A design that dropped the push would lose a byte.
- **Push and pop together on a single-entry queue.** A design that loaded the head tags from storage rather than from the incoming entry would show stale tags.
- **Draining to empty.** A design that cleared the tags would lose the final end-of-frame indication.
- **Pop on an empty queue.** A design that decremented anyway would corrupt occupancy.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       ovr;
        logic       crc_bad;
        logic       last;
        logic [7:0] data;
    } rxq_entry_t;

    typedef struct packed {
        logic ovr;
        logic crc_bad;
        logic last;
    } rxq_tags_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_t;

    localparam int STATUS_W = 32;

endpackage

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             overrun,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] rd_ptr_nxt,
    output logic [PTR_W-1:0] tail_ptr,
    output logic             head_load,
    output logic             head_from_input,
    output logic             not_empty
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_LESS  = CNT_W'(DEPTH - 1);

    occ_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             is_empty, is_full;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY:   if (push_ok) state_d = Q_PARTIAL;
            Q_PARTIAL: begin
                if (pop_ok && !push_ok && count_q == CNT_W'(1))
                    state_d = Q_EMPTY;
                else if (push_ok && !pop_ok && count_q == ONE_LESS)
                    state_d = Q_FULL;
            end
            Q_FULL:    if (pop_ok && !push_ok) state_d = Q_PARTIAL;
            default:   state_d = Q_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        is_empty        = (state_q == Q_EMPTY);
        is_full         = (state_q == Q_FULL);
        pop_ok          = rd_en && !is_empty;
        push_ok         = wr_en && (!is_full || pop_ok);
        overrun         = wr_en && is_full && !pop_ok;
        head_load       = (push_ok && is_empty) ||
                          (pop_ok && (count_q != CNT_W'(1) || push_ok));
        head_from_input = (count_q <= CNT_W'(1));
        not_empty       = !is_empty;
        rd_ptr_nxt      = (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + PTR_W'(1);
        tail_ptr        = (wr_ptr == '0) ? LAST_SLOT : wr_ptr - PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)
                rd_ptr <= rd_ptr_nxt;
            if (push_ok && !pop_ok)      count_q <= count_q + CNT_W'(1);
            else if (pop_ok && !push_ok) count_q <= count_q - CNT_W'(1);
        end
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == FULL_CNT && wr_en && !rd_en) |=>
            (count_q == FULL_CNT && wr_ptr == $past(wr_ptr)));

    // R10
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == FULL_CNT && wr_en && rd_en) |=>
            (count_q == FULL_CNT && rd_ptr != $past(rd_ptr)));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && rd_en && !wr_en) |=> (count_q == '0 && !not_empty));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_ok,
    input  logic             overrun,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] tail_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] rd_ptr_nxt,
    input  rxq_entry_t       wr_entry,
    output logic [7:0]       head_data,
    output rxq_tags_t        next_tags
);

    rxq_entry_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (push_ok)
            slots[wr_ptr] <= wr_entry;
        else if (overrun)
            slots[tail_ptr].ovr <= 1'b1;
    end

    always_comb begin
        head_data         = slots[rd_ptr].data;
        next_tags.ovr     = slots[rd_ptr_nxt].ovr;
        next_tags.crc_bad = slots[rd_ptr_nxt].crc_bad;
        next_tags.last    = slots[rd_ptr_nxt].last;
    end

    // R4
    tail_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> slots[$past(tail_ptr)].ovr);

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int TX_DEPTH = 32,
    localparam int TXC_W = $clog2(TX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                head_load,
    input  logic                head_from_input,
    input  rxq_tags_t           in_tags,
    input  rxq_tags_t           next_tags,
    input  logic                not_empty,
    input  logic [TXC_W-1:0]    tx_level,
    input  logic                tx_busy,
    input  logic                rx_locked,
    output logic [STATUS_W-1:0] stat_word
);

    rxq_tags_t tags_q;
    logic      tnf;

    always_ff @(posedge clk) begin
        if (!rst_n)
            tags_q <= '0;
        else if (head_load)
            tags_q <= head_from_input ? in_tags : next_tags;
    end

    always_comb begin
        tnf       = (tx_level < TXC_W'(TX_DEPTH));
        stat_word = {{(STATUS_W-7){1'b0}}, tags_q.ovr, tags_q.crc_bad,
                     tags_q.last, tnf, not_empty, tx_busy, rx_locked};
    end

    // R9
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && !head_load) |=> $stable(tags_q));

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int TX_DEPTH = 32,
    localparam int TXC_W   = $clog2(TX_DEPTH + 1),
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_last,
    input  logic             wr_crc_bad,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic [TXC_W-1:0] tx_level,
    input  logic             tx_busy,
    input  logic             rx_locked,
    output logic [31:0]      status
);

    logic             push_ok, pop_ok, overrun;
    logic             head_load, head_from_input, not_empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nxt, tail_ptr;
    rxq_entry_t       wr_entry;
    rxq_tags_t        in_tags, next_tags;

    always_comb begin
        wr_entry.ovr     = 1'b0;
        wr_entry.crc_bad = wr_crc_bad;
        wr_entry.last    = wr_last;
        wr_entry.data    = wr_data;
        in_tags.ovr      = 1'b0;
        in_tags.crc_bad  = wr_crc_bad;
        in_tags.last     = wr_last;
    end

    rxq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .push_ok(push_ok), .pop_ok(pop_ok), .overrun(overrun),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_nxt(rd_ptr_nxt),
        .tail_ptr(tail_ptr), .head_load(head_load),
        .head_from_input(head_from_input), .not_empty(not_empty)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .overrun(overrun),
        .wr_ptr(wr_ptr), .tail_ptr(tail_ptr), .rd_ptr(rd_ptr),
        .rd_ptr_nxt(rd_ptr_nxt), .wr_entry(wr_entry),
        .head_data(rd_data), .next_tags(next_tags)
    );

    rxq_status #(.TX_DEPTH(TX_DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n), .head_load(head_load),
        .head_from_input(head_from_input), .in_tags(in_tags),
        .next_tags(next_tags), .not_empty(not_empty), .tx_level(tx_level),
        .tx_busy(tx_busy), .rx_locked(rx_locked), .stat_word(status)
    );

    // R12
    rne_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[2] && wr_en) |=> status[2]);

endmodule

// File: tb/tb_rxq_tagged_fifo.sv
module tb_rxq_tagged_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int TX_DEPTH   = 32;
    localparam int TXC_W      = $clog2(TX_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0, wr_last = 1'b0, wr_crc_bad = 1'b0, rd_en = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic [TXC_W-1:0] tx_level = '0;
    logic             tx_busy = 1'b0, rx_locked = 1'b0;
    logic [7:0]       rd_data;
    logic [31:0]      status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [10:0] sb_q[$];
    logic [10:0] head_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_tagged_fifo #(.DEPTH(DEPTH), .TX_DEPTH(TX_DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_last(wr_last), .wr_crc_bad(wr_crc_bad), .rd_en(rd_en),
        .rd_data(rd_data), .tx_level(tx_level), .tx_busy(tx_busy),
        .rx_locked(rx_locked), .status(status)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and updates the expected queue
    task automatic drive(input bit wr, input logic [7:0] b, input bit last,
                         input bit crc, input bit rd);
        logic [10:0] tmp;
        @(posedge clk); #1;
        wr_en = wr; wr_data = b; wr_last = last; wr_crc_bad = crc; rd_en = rd;
        if (wr) begin
            if (sb_q.size() == DEPTH && !rd) begin
                tmp = sb_q[sb_q.size()-1];
                tmp[10] = 1'b1;
                sb_q[sb_q.size()-1] = tmp;
            end else begin
                sb_q.push_back({1'b0, crc, last, b});
            end
        end
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    // monitor: compares every pop against the scoreboard (R1, R2, R4)
    always @(negedge clk) begin
        if (rst_n && rd_en && status[2]) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 pop with empty scoreboard", {24'd0, rd_data}, 32'd0);
            end else begin
                head_exp = sb_q.pop_front();
                check(rd_data == head_exp[7:0], "R1 head byte",
                      {24'd0, rd_data}, {24'd0, head_exp[7:0]});
                check(status[6:4] == head_exp[10:8], "R2/R4 head tags",
                      {29'd0, status[6:4]}, {29'd0, head_exp[10:8]});
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6
        check(status == 32'h8, "R6 reset value", status, 32'h8);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(status == 32'h8, "R6 after release", status, 32'h8);

        // R8 and R5 bit positions of engine flags
        @(posedge clk); #1; tx_busy = 1'b1; rx_locked = 1'b0;
        @(negedge clk);
        check(status[1:0] == 2'b10, "R8 busy bit1", {30'd0, status[1:0]}, 32'h2);
        @(posedge clk); #1; tx_busy = 1'b0; rx_locked = 1'b1;
        @(negedge clk);
        check(status[1:0] == 2'b01, "R8 locked bit0", {30'd0, status[1:0]}, 32'h1);
        @(posedge clk); #1; rx_locked = 1'b0;

        // R7
        @(posedge clk); #1; tx_level = TXC_W'(TX_DEPTH);
        @(negedge clk);
        check(status[3] == 1'b0, "R7 tx full", {31'd0, status[3]}, 32'd0);
        @(posedge clk); #1; tx_level = TXC_W'(TX_DEPTH - 1);
        @(negedge clk);
        check(status[3] == 1'b1, "R7 tx one free", {31'd0, status[3]}, 32'd1);
        @(posedge clk); #1; tx_level = '0;

        // R12, R2 via push into empty queue
        drive(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        check(status == 32'h0000000C, "R12/R5 first push", status, 32'h0000000C);
        check(rd_data == 8'hA5, "R1 head after push", {24'd0, rd_data}, 32'hA5);
        drive(1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 8'h77, 1'b1, 1'b1, 1'b0);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        // R9 tags kept after drain, R12 not-empty cleared
        check(status == 32'h00000038, "R9/R12 drained", status, 32'h00000038);
        repeat (3) idle();
        @(negedge clk);
        check(status[6:4] == 3'b011, "R9 tags hold", {29'd0, status[6:4]}, 32'h3);

        // R11 pop on empty
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        check(status == 32'h00000038, "R11 empty pop", status, 32'h00000038);
        drive(1'b1, 8'h11, 1'b0, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        check(status[6:4] == 3'b000 && rd_data == 8'h11, "R11/R2 push after empty pop",
              {21'd0, status[6:4], rd_data}, {21'd0, 3'b000, 8'h11});
        // R2 head from input: push and pop on single entry
        drive(1'b1, 8'h22, 1'b1, 1'b1, 1'b1);
        idle();
        @(negedge clk);
        check(status[6:4] == 3'b011 && rd_data == 8'h22, "R2 single-entry swap",
              {21'd0, status[6:4], rd_data}, {21'd0, 3'b011, 8'h22});
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle();

        // R3, R4: fill, overflow twice, drain
        for (int i = 0; i < DEPTH; i++)
            drive(1'b1, 8'h40 + 8'(i), 1'(i == 3), 1'(i == 5), 1'b0);
        drive(1'b1, 8'hEE, 1'b1, 1'b1, 1'b0);
        drive(1'b1, 8'hEF, 1'b0, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        check(rd_data == 8'h40, "R3 head unchanged", {24'd0, rd_data}, 32'h40);
        for (int i = 0; i < DEPTH; i++)
            drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        check(status[2] == 1'b0, "R3 nothing extra stored", {31'd0, status[2]}, 32'd0);
        check(status[6] == 1'b1, "R4 overrun on last entry", {31'd0, status[6]}, 32'd1);
        check(status[31:7] == '0, "R5 reserved zero", status, {status[31:7] & 25'd0, status[6:0]});

        // R10: full then simultaneous push and pop
        for (int i = 0; i < DEPTH; i++)
            drive(1'b1, 8'h80 + 8'(i), 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++)
            drive(1'b1, 8'hC0 + 8'(i), 1'(i[0]), 1'b0, 1'b1);
        for (int i = 0; i < DEPTH; i++)
            drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        check(status[2] == 1'b0 && sb_q.size() == 0, "R10 all drained",
              {31'd0, status[2]}, 32'd0);

        // streaming pattern R1/R2
        drive(1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++)
            drive(1'b1, 8'h10 + 8'(i), 1'(i % 3 == 0), 1'(i[0]), 1'b1);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        check(status[2] == 1'b0, "R12 stream empty", {31'd0, status[2]}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule